// File: doc/BRIEF.md
# One-Time Program Memory Write/Verify Controller

This block is the device-side logic that lets an external programmer burn and read back a one-time programmable byte array while the part sits in its programming mode. The programmer never presents an address. Instead, a mode-controlled clear sets an internal address counter to zero. The counter then moves forward by one byte for every four rising edges seen on a pulse pin while verify mode is selected. A 4-bit mode input picks one of four operations: address clear, write, verify, or additional write.

Write data arrives as two 4-bit nibble groups. Read data leaves on matching nibble outputs together with an output-enable that stands in for the bus turning around. Each write opens a timed programming window. When the window ends, the addressed byte takes the AND of its old value and the data, and a one-cycle done pulse is raised. The additional-write window is a parameterised multiple of the number of writes that the current address needed. Supply sequencing and the analog programming pulse are left to the surrounding chip and the host.

The data path has no valid/ready handshake and applies no back-pressure. The host owns all timing: it holds data steady through a window and waits for the done pulse before changing mode.

Top module: `otp_prog_ctrl`

## Requirements
- R1: After reset the address is 0, `doe_o` and `wr_done_o` are low, both data outputs read 0, and every cell holds the erased value 8'hFF.
- R2: Mode code 4'b0001 (clear) sets the address counter to 0 and restarts the four-edge phase.
- R3: Mode code 4'b0100 (verify) raises `doe_o` and presents the byte at the current address. Each fourth rising edge of `xpin_i` in verify mode advances the address by one. Pin edges in any other mode change neither the address nor the phase.
- R4: The address counter wraps from its all-ones value to 0 on the advancing edge.
- R5: Entering mode 4'b0010 (write) from verify or clear opens a window of PULSE_CYC cycles. At its end the byte is updated and `wr_done_o` is high for exactly one cycle, PULSE_CYC cycles after the first clock edge in write mode.
- R6: A write can only move bits from 1 to 0: the new byte is the old byte AND {`dhi_i`,`dlo_i`}.
- R7: A window performs at most one update. Leaving write mode for verify or clear before the window ends cancels it with no update and no done pulse. A new window opens only after verify or clear, or on a switch between the two write kinds.
- R8: Mode 4'b1000 (additional write) opens a window of ADD_MULT x max(n,1) x PULSE_CYC cycles and then applies the same AND update. Here n counts the completed writes at the current address since the last clear or address advance, saturating at MAX_TRIES.
- R9: `doe_o` is high only in verify mode, and both data outputs are 0 whenever it is low.
- R10: Any mode code other than the four listed holds all state. The address, the phase, and a running window are all frozen, and a frozen window resumes where it stopped.
- R11: Addresses at or above 2^ARR_AW read 8'hFF and writes to them leave nothing behind, though the window and done pulse still occur.
- R12: Bits 3:0 of a byte travel on `dlo_i`/`dlo_o` and bits 7:4 on `dhi_i`/`dhi_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i | input | 4 | Operation select code |
| xpin_i | input | 1 | Address-advance pulse pin (asynchronous, synchronised inside) |
| dlo_i | input | 4 | Write data, low nibble |
| dhi_i | input | 4 | Write data, high nibble |
| dlo_o | output | 4 | Verify data, low nibble |
| dhi_o | output | 4 | Verify data, high nibble |
| doe_o | output | 1 | Data outputs driven (verify mode) |
| wr_done_o | output | 1 | One-cycle pulse at the end of each programming window |

## Verification
The assertions assume that the host changes `mode_i` and the data nibbles only between clock edges. They also assume that each level of `xpin_i` lasts at least one full clock, so the synchroniser never merges two edges. The bench drives every input on the falling edge and keeps the pin high for one cycle and low for one cycle. It waits four cycles after the last pulse before it changes mode, so the synchroniser latency has settled. The bench also keeps write data constant across each window, as a programmer would.

// File: rtl/otp_prog_pkg.sv
package otp_prog_pkg;

  localparam logic [3:0] MC_CLR = 4'b0001;
  localparam logic [3:0] MC_WR  = 4'b0010;
  localparam logic [3:0] MC_VFY = 4'b0100;
  localparam logic [3:0] MC_ADW = 4'b1000;

  typedef enum logic [2:0] {
    OP_HOLD,
    OP_CLR,
    OP_WR,
    OP_VFY,
    OP_ADW
  } otp_op_e;

  typedef enum logic [1:0] {
    WS_IDLE,
    WS_RUN,
    WS_SPENT
  } win_state_e;

  function automatic otp_op_e decode_mode(input logic [3:0] code);
    case (code)
      MC_CLR:  return OP_CLR;
      MC_WR:   return OP_WR;
      MC_VFY:  return OP_VFY;
      MC_ADW:  return OP_ADW;
      default: return OP_HOLD;
    endcase
  endfunction

endpackage

// File: rtl/otp_pin_edge.sv
module otp_pin_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic rise_o
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   lvl_q;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= pin_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= sync_q[SYNC_STAGES-1];
  end

  assign rise_o = sync_q[SYNC_STAGES-1] & ~lvl_q;

  AST_RISE_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o); // R3

endmodule

// File: rtl/otp_addr_seq.sv
module otp_addr_seq
  import otp_prog_pkg::*;
#(
  parameter int ADDR_W          = 14,
  parameter int PULSES_PER_ADDR = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  otp_op_e           op_i,
  input  logic              rise_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              adv_o
);

  localparam int PH_W = (PULSES_PER_ADDR > 2) ? $clog2(PULSES_PER_ADDR) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(PULSES_PER_ADDR - 1);

  logic [PH_W-1:0]   phase_q;
  logic [ADDR_W-1:0] addr_q;

  assign adv_o  = (op_i == OP_VFY) && rise_i && (phase_q == PH_LAST);
  assign addr_o = addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      phase_q <= '0;
    end else begin
      case (op_i)
        OP_CLR: begin
          addr_q  <= '0;
          phase_q <= '0;
        end
        OP_VFY: begin
          if (rise_i) begin
            if (phase_q == PH_LAST) begin
              phase_q <= '0;
              addr_q  <= addr_q + 1'b1;
            end else begin
              phase_q <= phase_q + 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_CLR) |=> (addr_o == '0)); // R2

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    adv_o |=> (addr_o == ADDR_W'($past(addr_o) + 1'b1))); // R4

  AST_ADDR_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv_o && op_i != OP_CLR) |=> $stable(addr_o)); // R10

endmodule

// File: rtl/otp_pulse_timer.sv
module otp_pulse_timer
  import otp_prog_pkg::*;
#(
  parameter int PULSE_CYC = 50000,
  parameter int ADD_MULT  = 3,
  parameter int MAX_TRIES = 25
) (
  input  logic    clk,
  input  logic    rst_n,
  input  otp_op_e op_i,
  input  logic    addr_adv_i,
  output logic    fire_o,
  output logic    done_o
);

  localparam int TRY_W   = $clog2(MAX_TRIES + 1);
  localparam int MAX_WIN = PULSE_CYC * ADD_MULT * MAX_TRIES;
  localparam int CNT_W   = $clog2(MAX_WIN + 1) + 1;
  localparam logic [TRY_W-1:0] TRY_SAT  = TRY_W'(MAX_TRIES);
  localparam logic [CNT_W-1:0] WR_LEN   = CNT_W'(PULSE_CYC);
  localparam logic [CNT_W-1:0] ADW_UNIT = CNT_W'(PULSE_CYC * ADD_MULT);

  win_state_e       st_q;
  otp_op_e          kind_q;
  logic [CNT_W-1:0] cnt_q;
  logic [TRY_W-1:0] tries_q;
  logic [TRY_W-1:0] tries_eff;
  logic [CNT_W-1:0] adw_len;
  logic             done_q;
  logic             wr_kind;

  assign wr_kind   = (op_i == OP_WR) || (op_i == OP_ADW);
  assign tries_eff = (tries_q == '0) ? TRY_W'(1) : tries_q;
  assign adw_len   = ADW_UNIT * CNT_W'(tries_eff);
  assign fire_o    = wr_kind && (st_q == WS_RUN) && (kind_q == op_i) && (cnt_q == CNT_W'(1));
  assign done_o    = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= WS_IDLE;
      kind_q  <= OP_HOLD;
      cnt_q   <= '0;
      tries_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= fire_o;
      case (op_i)
        OP_CLR, OP_VFY: st_q <= WS_IDLE;
        OP_WR, OP_ADW: begin
          if (st_q == WS_IDLE || kind_q != op_i) begin
            st_q   <= WS_RUN;
            kind_q <= op_i;
            cnt_q  <= (op_i == OP_WR) ? WR_LEN : adw_len;
          end else if (st_q == WS_RUN) begin
            if (cnt_q == CNT_W'(1)) st_q  <= WS_SPENT;
            else                    cnt_q <= cnt_q - 1'b1;
          end
        end
        default: ;
      endcase
      if (op_i == OP_CLR || addr_adv_i)
        tries_q <= '0;
      else if (fire_o && kind_q == OP_WR && tries_q != TRY_SAT)
        tries_q <= tries_q + 1'b1;
    end
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R5

  AST_DONE_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ($past(op_i) == OP_WR || $past(op_i) == OP_ADW)); // R7

  AST_TRIES_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    tries_q <= TRY_SAT); // R8

endmodule

// File: rtl/otp_cell_array.sv
module otp_cell_array #(
  parameter int ADDR_W = 14,
  parameter int ARR_AW = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [7:0]        wr_data_i,
  output logic [7:0]        rd_data_o
);

  localparam int DEPTH = 1 << ARR_AW;

  logic [7:0]        cells [DEPTH];
  logic              in_range;
  logic [ARR_AW-1:0] idx;

  assign idx = addr_i[ARR_AW-1:0];

  generate
    if (ADDR_W > ARR_AW) begin : g_partial
      assign in_range = (addr_i[ADDR_W-1:ARR_AW] == '0);
    end else begin : g_full
      assign in_range = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= 8'hFF;
    end else if (wr_en_i && in_range) begin
      cells[idx] <= cells[idx] & wr_data_i;
    end
  end

  assign rd_data_o = in_range ? cells[idx] : 8'hFF;

  AST_ONLY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (!$stable(addr_i) || ((rd_data_o & ~$past(rd_data_o)) == 8'h00))); // R6

endmodule

// File: rtl/otp_prog_ctrl.sv
module otp_prog_ctrl
  import otp_prog_pkg::*;
#(
  parameter int ADDR_W          = 14,
  parameter int ARR_AW          = 10,
  parameter int PULSES_PER_ADDR = 4,
  parameter int SYNC_STAGES     = 2,
  parameter int PULSE_CYC       = 50000,
  parameter int ADD_MULT        = 3,
  parameter int MAX_TRIES       = 25
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] mode_i,
  input  logic       xpin_i,
  input  logic [3:0] dlo_i,
  input  logic [3:0] dhi_i,
  output logic [3:0] dlo_o,
  output logic [3:0] dhi_o,
  output logic       doe_o,
  output logic       wr_done_o
);

  otp_op_e           op;
  logic              rise;
  logic              adv;
  logic              fire;
  logic [ADDR_W-1:0] addr;
  logic [7:0]        rd_byte;

  assign op = decode_mode(mode_i);

  otp_pin_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n), .pin_i(xpin_i), .rise_o(rise)
  );

  otp_addr_seq #(.ADDR_W(ADDR_W), .PULSES_PER_ADDR(PULSES_PER_ADDR)) u_seq (
    .clk(clk), .rst_n(rst_n), .op_i(op), .rise_i(rise), .addr_o(addr), .adv_o(adv)
  );

  otp_pulse_timer #(.PULSE_CYC(PULSE_CYC), .ADD_MULT(ADD_MULT), .MAX_TRIES(MAX_TRIES)) u_tmr (
    .clk(clk), .rst_n(rst_n), .op_i(op), .addr_adv_i(adv), .fire_o(fire), .done_o(wr_done_o)
  );

  otp_cell_array #(.ADDR_W(ADDR_W), .ARR_AW(ARR_AW)) u_arr (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .wr_en_i(fire),
    .wr_data_i({dhi_i, dlo_i}), .rd_data_o(rd_byte)
  );

  assign doe_o = (op == OP_VFY);
  assign dlo_o = doe_o ? rd_byte[3:0] : 4'h0;
  assign dhi_o = doe_o ? rd_byte[7:4] : 4'h0;

endmodule

// File: tb/otp_prog_ctrl_tb_top.sv
module otp_prog_ctrl_tb_top;
  import otp_prog_pkg::*;

  localparam int P  = 8;
  localparam int AM = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] mode = 4'h0;
  logic       xpin = 1'b0;
  logic [3:0] dlo = 4'h0, dhi = 4'h0;
  logic [3:0] dlo_o, dhi_o;
  logic       doe_o, wr_done_o;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  otp_prog_ctrl #(.ADDR_W(8), .ARR_AW(7), .PULSES_PER_ADDR(4), .SYNC_STAGES(2),
                  .PULSE_CYC(P), .ADD_MULT(AM), .MAX_TRIES(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .xpin_i(xpin), .dlo_i(dlo), .dhi_i(dhi),
    .dlo_o(dlo_o), .dhi_o(dhi_o), .doe_o(doe_o), .wr_done_o(wr_done_o)
  );

  // {first write, second write, expected byte}
  localparam logic [23:0] VEC [0:5] = '{24'hA5FFA5, 24'h3C0F0C, 24'h00FF00,
                                        24'hFFFFFF, 24'h966900, 24'hF77F77};

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic win(input logic [3:0] m, input logic [7:0] d, input int len, input string tag);
    int  n = 0;
    bit  seen = 0;
    @(negedge clk);
    mode = m;
    {dhi, dlo} = d;
    while (!seen && n < 2000) begin
      @(negedge clk);
      n++;
      if (wr_done_o) seen = 1;
    end
    check(tag, n, len + 1);
    @(negedge clk);
    check(tag, wr_done_o, 0);
  endtask

  task automatic rd(input logic [7:0] exp, input string tag);
    @(negedge clk);
    mode = MC_VFY;
    #1;
    check(tag, {dhi_o, dlo_o}, exp);
  endtask

  task automatic pulses(input int k);
    repeat (k) begin
      @(negedge clk); xpin = 1'b1;
      @(negedge clk); xpin = 1'b0;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 doe", doe_o, 0);
    check("R1 done", wr_done_o, 0);
    check("R1 bus", {dhi_o, dlo_o}, 0);
    rd(8'hFF, "R1 erased");

    // table walk: two writes per address then advance
    @(negedge clk); mode = MC_CLR;
    @(negedge clk); mode = MC_VFY;
    for (int i = 0; i < 6; i++) begin
      win(MC_WR, VEC[i][23:16], P, "R5 first");
      rd(VEC[i][23:16], "R6 first");
      win(MC_WR, VEC[i][15:8], P, "R5 second");
      rd(VEC[i][7:0], "R6 and");
      check("R9 doe", doe_o, 1);
      pulses(4);
    end

    // R7: cancelled window at address 6
    begin
      bit seen = 0;
      @(negedge clk); mode = MC_WR; {dhi, dlo} = 8'h00;
      repeat (3) begin @(negedge clk); if (wr_done_o) seen = 1; end
      rd(8'hFF, "R7 cancel");
      check("R7 no done", seen, 0);
    end

    // R10: frozen window resumes
    begin
      int n = 0;
      bit seen = 0;
      @(negedge clk); mode = MC_WR; {dhi, dlo} = 8'h00;
      repeat (3) @(negedge clk);
      mode = 4'h0;
      #1;
      check("R9 hold bus", {doe_o, dhi_o, dlo_o}, 0);
      repeat (5) @(negedge clk);
      mode = MC_WR;
      while (!seen && n < 2000) begin
        @(negedge clk); n++;
        if (wr_done_o) seen = 1;
      end
      check("R10 resume", n, P - 2);
      rd(8'h00, "R5 freeze write");
    end

    // R8: additional write lengths
    win(MC_ADW, 8'hFF, AM * 1 * P, "R8 one try");
    rd(8'h00, "R8 data");
    win(MC_WR, 8'h00, P, "R5 retry");
    rd(8'h00, "R6 retry");
    win(MC_ADW, 8'hFF, AM * 2 * P, "R8 two tries");
    rd(8'h00, "R8 data");
    for (int j = 0; j < 3; j++) begin
      win(MC_WR, 8'h00, P, "R5 more");
      rd(8'h00, "R6 more");
    end
    win(MC_ADW, 8'hFF, AM * 4 * P, "R8 saturate");
    rd(8'h00, "R8 data");
    pulses(4);
    win(MC_ADW, 8'h5A, AM * P, "R8 fresh");
    rd(8'h5A, "R8 fresh data");

    // R2, R3, R12
    @(negedge clk); mode = MC_CLR;
    rd(8'hA5, "R2 clear");
    check("R12 low", dlo_o, 4'h5);
    check("R12 high", dhi_o, 4'hA);
    pulses(3);
    rd(8'hA5, "R3 three edges");
    pulses(1);
    rd(8'h0C, "R3 fourth edge");
    pulses(4);
    rd(8'h00, "R3 addr2");

    // R3: edges in write mode ignored
    @(negedge clk); mode = MC_WR; {dhi, dlo} = 8'hFF;
    pulses(4);
    #1;
    check("R9 write bus", {doe_o, dhi_o, dlo_o}, 0);
    rd(8'h00, "R3 write edges");
    pulses(4);
    rd(8'hFF, "R3 phase kept");

    // R10: undefined code holds address
    @(negedge clk); mode = 4'b0110;
    pulses(4);
    rd(8'hFF, "R10 undefined");
    pulses(4);
    rd(8'h00, "R10 then addr4");

    // R11: beyond the array
    @(negedge clk); mode = MC_CLR;
    @(negedge clk); mode = MC_VFY;
    pulses(4 * 130);
    rd(8'hFF, "R11 erased");
    win(MC_WR, 8'h00, P, "R11 window");
    rd(8'hFF, "R11 no store");

    // R4: wrap
    pulses(4 * 126);
    rd(8'hA5, "R4 wrap");

    finish_run();
  end

endmodule